// File: doc/BRIEF.md
# Time-Multiplexed Two-Digit Seven-Segment Driver

This block shows a 4-bit binary value (0 to 15) as two decimal digits on a pair of seven-segment LED displays whose segment lines are wired together. Only one display is enabled at a time. A free-running refresh counter divides its period into two equal halves: the ones digit is enabled during the first half and the tens digit during the second. Cycling faster than the eye can follow makes both digits appear lit together.

On chip, the binary value is split into a tens digit and a ones digit. A multiplexer steered by the refresh phase routes one of them to a decimal-to-segment decoder. When the value is below ten, the tens slot still shows the pattern for zero. The full refresh period is a parameter given in clock cycles. At 50 MHz, 800000 cycles gives a 16 ms period for hardware and 800 cycles gives 16 us for simulation.

Top module: `dual_digit_seg_driver`

## Requirements
- R1: A synchronous reset clears the refresh counter. In the first cycle after reset is released, and throughout reset, the ones display is enabled (`digitEn` = 2'b01).
- R2: Exactly one display is enabled in every cycle. Bit 0 of `digitEn` enables the ones display and bit 1 enables the tens display.
- R3: Counting from reset release, the ones display stays enabled for REFRESH_CYCLES/2 cycles and then the tens display for REFRESH_CYCLES/2 cycles. The pattern repeats every REFRESH_CYCLES cycles with no gap.
- R4: While the tens display is enabled and `valueIn` is 10 or more, `segOut` shows digit 1 (7'h06).
- R5: While the ones display is enabled, `segOut` shows `valueIn` minus 10 when `valueIn` is 10 or more, and `valueIn` itself otherwise. The output follows a change of `valueIn` in the same cycle.
- R6: Segments are active high in bit order g f e d c b a, with a in bit 0. The digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R7: While the tens display is enabled and `valueIn` is below 10, `segOut` shows the pattern for zero, 7'h3F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valueIn | input | 4 | Binary value to show (0 to 15) |
| segOut | output | 7 | Shared segment lines, gfedcba, active high |
| digitEn | output | 2 | One-hot display enable: bit 0 ones, bit 1 tens |

## Verification
The bench sweeps all sixteen input values for one full refresh period each and compares both outputs every cycle. This covers the 9/10 boundary, where a wrong comparator would show a stray 1 in the tens slot or leave the ones digit above nine and blank it. Values below ten check that the tens slot shows zero rather than going dark. Phase edges are checked in the exact cycle, so an off-by-one counter wrap or half-point shows up as an enable flipping one cycle early or late. A reset in the middle of the tens half checks that the sequence restarts on the ones display.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

  // Strobes from the refresh control to the digit datapath
  typedef struct packed {
    logic showTens;
    logic showOnes;
  } refreshStrobe_t;

  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;
  localparam logic [SEG_W-1:0] SEG_BLANK = 7'h00;

endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import seg_drv_pkg::*;
#(
  parameter int REFRESH_CYCLES = 800000
) (
  input  logic           clk,
  input  logic           rst,
  output refreshStrobe_t strobe
);

  localparam int CNT_W = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(REFRESH_CYCLES - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(REFRESH_CYCLES / 2);

  logic [CNT_W-1:0] refreshCnt;
  logic             inTensHalf;

  always_ff @(posedge clk) begin
    if (rst) begin
      refreshCnt <= '0;
    end else if (refreshCnt == LAST_C) begin
      refreshCnt <= '0;
    end else begin
      refreshCnt <= refreshCnt + 1'b1;
    end
  end

  always_comb begin
    inTensHalf      = (refreshCnt >= HALF_C);
    strobe.showTens = inTensHalf;
    strobe.showOnes = !inTensHalf;
  end

endmodule

// File: rtl/bcd_split.sv
module bcd_split
  import seg_drv_pkg::*;
#(
  parameter int VALUE_W = 4
) (
  input  logic [VALUE_W-1:0] binIn,
  output logic [DIGIT_W-1:0] tensDigit,
  output logic [DIGIT_W-1:0] onesDigit
);

  localparam logic [VALUE_W-1:0] TEN_C = VALUE_W'(10);

  logic              atLeastTen;
  logic [VALUE_W-1:0] reduced;

  always_comb begin
    atLeastTen = (binIn >= TEN_C);
    reduced    = binIn - TEN_C;
    tensDigit  = DIGIT_W'(atLeastTen);
    onesDigit  = atLeastTen ? DIGIT_W'(reduced) : DIGIT_W'(binIn);
  end

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_drv_pkg::*;
(
  input  logic [DIGIT_W-1:0] digitIn,
  output logic [SEG_W-1:0]   segPattern
);

  always_comb begin
    unique case (digitIn)
      4'd0:    segPattern = 7'h3F;
      4'd1:    segPattern = 7'h06;
      4'd2:    segPattern = 7'h5B;
      4'd3:    segPattern = 7'h4F;
      4'd4:    segPattern = 7'h66;
      4'd5:    segPattern = 7'h6D;
      4'd6:    segPattern = 7'h7D;
      4'd7:    segPattern = 7'h07;
      4'd8:    segPattern = 7'h7F;
      4'd9:    segPattern = 7'h6F;
      default: segPattern = SEG_BLANK;
    endcase
  end

endmodule

// File: rtl/digit_datapath.sv
module digit_datapath
  import seg_drv_pkg::*;
#(
  parameter int VALUE_W = 4
) (
  input  logic [VALUE_W-1:0] valueIn,
  input  refreshStrobe_t     strobe,
  output logic [SEG_W-1:0]   segOut,
  output logic [1:0]         digitEn
);

  logic [DIGIT_W-1:0] tensDigit;
  logic [DIGIT_W-1:0] onesDigit;
  logic [DIGIT_W-1:0] selDigit;

  bcd_split #(.VALUE_W(VALUE_W)) split_i (
    .binIn     (valueIn),
    .tensDigit (tensDigit),
    .onesDigit (onesDigit)
  );

  always_comb begin
    selDigit = strobe.showTens ? tensDigit : onesDigit;
    digitEn  = {strobe.showTens, strobe.showOnes};
  end

  seg_decoder dec_i (
    .digitIn    (selDigit),
    .segPattern (segOut)
  );

endmodule

// File: rtl/dual_digit_seg_driver.sv
module dual_digit_seg_driver
  import seg_drv_pkg::*;
#(
  parameter int REFRESH_CYCLES = 800000,
  parameter int VALUE_W        = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VALUE_W-1:0] valueIn,
  output logic [SEG_W-1:0]   segOut,
  output logic [1:0]         digitEn
);

  refreshStrobe_t strobe;

  refresh_ctrl #(.REFRESH_CYCLES(REFRESH_CYCLES)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  digit_datapath #(.VALUE_W(VALUE_W)) dp_i (
    .valueIn (valueIn),
    .strobe  (strobe),
    .segOut  (segOut),
    .digitEn (digitEn)
  );

endmodule

// File: rtl/seg_drv_checker.sv
module seg_drv_checker #(
  parameter int REFRESH_CYCLES = 800000,
  parameter int VALUE_W        = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [VALUE_W-1:0] valueIn,
  input logic [6:0]         segOut,
  input logic [1:0]         digitEn
);

  localparam int HALF = REFRESH_CYCLES / 2;

  // R2: exactly one display enabled
  assert_one_enable_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(digitEn) == 1);

  // R1: reset leaves the ones display enabled
  assert_reset_ones_R1: assert property (@(posedge clk)
    rst |=> (digitEn == 2'b01));

  // R7: tens slot shows zero below ten
  assert_tens_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (digitEn == 2'b10 && valueIn < VALUE_W'(10)) |-> (segOut == 7'h3F));

  // R4: tens slot shows one from ten upwards
  assert_tens_one_R4: assert property (@(posedge clk) disable iff (rst)
    (digitEn == 2'b10 && valueIn >= VALUE_W'(10)) |-> (segOut == 7'h06));

  // R3: each enable phase lasts exactly half a period
  logic [1:0] prevEn;
  int         runLen;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevEn <= 2'b01;
      runLen <= 0;
    end else begin
      if (digitEn != prevEn) begin
        assert_phase_len_R3: assert (runLen == HALF)
          else $error("phase length %0d, expected %0d", runLen, HALF);
        prevEn <= digitEn;
        runLen <= 1;
      end else begin
        runLen <= runLen + 1;
      end
    end
  end

endmodule

bind dual_digit_seg_driver seg_drv_checker #(
  .REFRESH_CYCLES(REFRESH_CYCLES),
  .VALUE_W(VALUE_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .valueIn (valueIn),
  .segOut  (segOut),
  .digitEn (digitEn)
);

// File: tb/dual_digit_seg_driver_tb_top.sv
`timescale 1ns/1ps
module dual_digit_seg_driver_tb_top;

  localparam int P    = 800;
  localparam int HALF = P / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] valueIn = 4'd0;
  logic [6:0] segOut;
  logic [1:0] digitEn;

  int vectors  = 0;
  int failures = 0;
  int modelCnt = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  dual_digit_seg_driver #(.REFRESH_CYCLES(P)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .valueIn (valueIn),
    .segOut  (segOut),
    .digitEn (digitEn)
  );

  function automatic logic [6:0] segOf(int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // Compare outputs against the behavioural model at the current point
  task automatic compareNow();
    int v;
    bit tensPhase;
    logic [1:0] expEn;
    logic [6:0] expSeg;
    v         = int'(valueIn);
    tensPhase = (modelCnt >= HALF);
    expEn     = tensPhase ? 2'b10 : 2'b01;
    expSeg    = tensPhase ? segOf(v / 10) : segOf(v % 10);
    vectors++;
    if (digitEn !== expEn) begin
      failures++;
      $display("FAIL R2 R3 digitEn value=%0d cnt=%0d actual=%b expected=%b",
               v, modelCnt, digitEn, expEn);
    end else if (segOut !== expSeg) begin
      failures++;
      if (!tensPhase)
        $display("FAIL R5 R6 ones segOut value=%0d actual=%h expected=%h", v, segOut, expSeg);
      else if (v >= 10)
        $display("FAIL R4 tens segOut value=%0d actual=%h expected=%h", v, segOut, expSeg);
      else
        $display("FAIL R7 tens segOut value=%0d actual=%h expected=%h", v, segOut, expSeg);
    end
  endtask

  task automatic stepClock();
    @(posedge clk);
    if (rst) modelCnt = 0;
    else     modelCnt = (modelCnt + 1) % P;
    @(negedge clk);
  endtask

  task automatic checkReset(string tag);
    vectors++;
    if (digitEn !== 2'b01) begin
      failures++;
      $display("FAIL R1 %s digitEn actual=%b expected=01", tag, digitEn);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) stepClock();
    checkReset("in reset");
    rst = 1'b0;
    modelCnt = 0;
    checkReset("after release");

    // R4 R5 R6 R7: one full period per value, compared every cycle
    for (int v = 0; v < 16; v++) begin
      for (int i = 0; i < P; i++) begin
        valueIn = 4'(v);
        #1;
        compareNow();
        stepClock();
      end
    end

    // R1: reset in the middle of the tens half restarts on the ones display
    valueIn = 4'd13;
    while (modelCnt != HALF + 37) stepClock();
    compareNow();
    rst = 1'b1;
    stepClock();
    rst = 1'b0;
    modelCnt = 0;
    checkReset("mid-period");
    for (int i = 0; i < P + 5; i++) begin
      compareNow();
      stepClock();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

endmodule